// File: doc/BRIEF.md
# Keyed Reset Pulse Configuration Register

This block sits beside a watchdog counter. It holds the shape of the external reset pulse that the watchdog issues when it expires. The register has three parts: a pulse length field, a polarity attribute and a drive-type attribute. The length field takes the low bits of every write directly. The two attribute bits are guarded. An attribute changes only when the top byte of the write carries one of four exact 8-bit keys, and any other top byte leaves both attributes as they were.

When the watchdog raises its one-cycle expiry strobe, a pulse generator asserts the external reset for a number of ticks set by the stored length. It uses the selected polarity. A separate output-enable pin lets the output behave as open-drain or as push-pull.

Software updates the register through a single write port. The read port shows the stored fields at all times. The tick input sets the timebase of the pulse, so the pulse counts only on cycles where the tick is high.

Top module: `wdt_rstcfg`

## Requirements
- R1: After reset the read value is 0x000000FF: the length is 255, and the output is active-low and open-drain. The reset output then sits at 1 with its enable at 0.
- R2: A write stores data bits 19:0 as the length on the next cycle. Read bits 29:20 are always zero, whatever value is written there.
- R3: A write whose bits 31:24 equal 0xA5 sets read bit 31 (active-high). A write whose bits 31:24 equal 0x5A clears it (active-low).
- R4: A write whose bits 31:24 equal 0xA8 sets read bit 30 (push-pull). A write whose bits 31:24 equal 0x8A clears it (open-drain).
- R5: A write whose bits 31:24 hold any value other than the four keys, zero included, leaves bits 31:30 unchanged, while its length bits still take effect.
- R6: An expiry strobe starts a pulse. With the tick high on every cycle, the reset output stays asserted for length+1 cycles after the strobe edge and is then released.
- R7: A strobe that arrives during a pulse restarts the count, so the pulse lasts length+1 ticks from the newer strobe.
- R8: The reset output equals the pulse state when bit 31 is 1, and equals its inverse when bit 31 is 0.
- R9: When bit 30 is 1, the output enable is always 1. When bit 30 is 0, the enable is 1 only while a pulse is asserted with bit 31 at 0.
- R10: A pulse advances only on cycles with the tick high. Without ticks it stays asserted.
- R11: A strobe loads the length stored before that cycle. A write to the length during the strobe cycle or during a pulse does not change the pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read view |
| expire_i | input | 1 | Watchdog expiry strobe |
| tick_i | input | 1 | Pulse timebase enable |
| rst_pulse_o | output | 1 | External reset level |
| rst_pulse_oe_o | output | 1 | External reset output enable |

## Verification
The bench builds the block with its default parameters: a 32-bit register and a 20-bit length field reset to 255. This lets full-width random writes test the reserved bits 29:20, together with every key and many non-key top bytes. Random writes mostly keep the length small, below 8, so that many pulses run to their release inside the run. Retriggers, tickless stretches and writes during the strobe cycle therefore all come up next to the directed length counts.

// File: rtl/wdt_rstcfg_pkg.sv
package wdt_rstcfg_pkg;

  localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
  localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
  localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_SET_HIGH,
    ACT_SET_LOW,
    ACT_SET_PP,
    ACT_SET_OD
  } key_act_e;

  typedef struct packed {
    logic pol_high;
    logic push_pull;
  } attr_t;

  function automatic key_act_e decode_key(input logic [7:0] top);
    case (top)
      KEY_POL_HIGH: return ACT_SET_HIGH;
      KEY_POL_LOW:  return ACT_SET_LOW;
      KEY_DRV_PP:   return ACT_SET_PP;
      KEY_DRV_OD:   return ACT_SET_OD;
      default:      return ACT_NONE;
    endcase
  endfunction

  function automatic attr_t apply_key(input attr_t cur, input key_act_e act);
    attr_t nxt;
    nxt = cur;
    case (act)
      ACT_SET_HIGH: nxt.pol_high  = 1'b1;
      ACT_SET_LOW:  nxt.pol_high  = 1'b0;
      ACT_SET_PP:   nxt.push_pull = 1'b1;
      ACT_SET_OD:   nxt.push_pull = 1'b0;
      default:      nxt = cur;
    endcase
    return nxt;
  endfunction

  function automatic logic pad_level(input logic active, input logic pol_high);
    return pol_high ? active : ~active;
  endfunction

  function automatic logic pad_enable(input logic active, input attr_t a);
    return a.push_pull | (active & ~a.pol_high);
  endfunction

endpackage

// File: rtl/wdt_rstcfg_cfg.sv
module wdt_rstcfg_cfg
  import wdt_rstcfg_pkg::*;
#(
  parameter int unsigned REG_W       = 32,
  parameter int unsigned WIDTH_W     = 20,
  parameter logic [WIDTH_W-1:0] RESET_WIDTH = 'hFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [7:0]         key_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic [WIDTH_W-1:0] width_o,
  output attr_t              attr_o,
  output logic               key_hit_o,
  output logic [REG_W-1:0]   rdata_o
);

  localparam int unsigned POL_BIT = REG_W - 1;
  localparam int unsigned DRV_BIT = REG_W - 2;

  key_act_e act;
  attr_t    attr_q;
  logic [WIDTH_W-1:0] width_q;

  assign act       = decode_key(key_i);
  assign key_hit_o = wr_i && (act != ACT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q <= RESET_WIDTH;
      attr_q  <= '0;
    end else if (wr_i) begin
      width_q <= width_i;
      attr_q  <= apply_key(attr_q, act);
    end
  end

  always_comb begin
    rdata_o                = '0;
    rdata_o[WIDTH_W-1:0]   = width_q;
    rdata_o[POL_BIT]       = attr_q.pol_high;
    rdata_o[DRV_BIT]       = attr_q.push_pull;
  end

  assign width_o = width_q;
  assign attr_o  = attr_q;

endmodule

// File: rtl/wdt_rstcfg_pulse.sv
module wdt_rstcfg_pulse #(
  parameter int unsigned WIDTH_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic               tick_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               active_o,
  output logic [WIDTH_W-1:0] count_o,
  output logic               done_o
);

  logic               active_q;
  logic [WIDTH_W-1:0] cnt_q;

  assign done_o = active_q && tick_i && !strobe_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (strobe_i) begin
      active_q <= 1'b1;
      cnt_q    <= width_i;
    end else if (active_q && tick_i) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign count_o  = cnt_q;

endmodule

// File: rtl/wdt_rstcfg_pad.sv
module wdt_rstcfg_pad
  import wdt_rstcfg_pkg::*;
(
  input  logic  active_i,
  input  attr_t attr_i,
  output logic  level_o,
  output logic  oe_o
);

  assign level_o = pad_level(active_i, attr_i.pol_high);
  assign oe_o    = pad_enable(active_i, attr_i);

endmodule

// File: rtl/wdt_rstcfg.sv
module wdt_rstcfg
  import wdt_rstcfg_pkg::*;
#(
  parameter int unsigned REG_W       = 32,
  parameter int unsigned WIDTH_W     = 20,
  parameter logic [WIDTH_W-1:0] RESET_WIDTH = 'hFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  input  logic             expire_i,
  input  logic             tick_i,
  output logic             rst_pulse_o,
  output logic             rst_pulse_oe_o
);

  localparam int unsigned KEY_LSB = REG_W - 8;

  logic [WIDTH_W-1:0] cfg_width;
  attr_t              cfg_attr;
  logic               key_hit;
  logic               pulse_active;
  logic [WIDTH_W-1:0] pulse_cnt;
  logic               pulse_done;
  logic               rsvd_unused;

  assign rsvd_unused = ^cfg_wdata_i[KEY_LSB-1:WIDTH_W];

  wdt_rstcfg_cfg #(
    .REG_W(REG_W), .WIDTH_W(WIDTH_W), .RESET_WIDTH(RESET_WIDTH)
  ) cfg_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_wr_i),
    .key_i     (cfg_wdata_i[REG_W-1:KEY_LSB]),
    .width_i   (cfg_wdata_i[WIDTH_W-1:0]),
    .width_o   (cfg_width),
    .attr_o    (cfg_attr),
    .key_hit_o (key_hit),
    .rdata_o   (cfg_rdata_o)
  );

  wdt_rstcfg_pulse #(.WIDTH_W(WIDTH_W)) pulse_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (expire_i),
    .tick_i   (tick_i),
    .width_i  (cfg_width),
    .active_o (pulse_active),
    .count_o  (pulse_cnt),
    .done_o   (pulse_done)
  );

  wdt_rstcfg_pad pad_i (
    .active_i (pulse_active),
    .attr_i   (cfg_attr),
    .level_o  (rst_pulse_o),
    .oe_o     (rst_pulse_oe_o)
  );

endmodule

// File: rtl/wdt_rstcfg_chk.sv
module wdt_rstcfg_chk #(
  parameter int unsigned REG_W   = 32,
  parameter int unsigned WIDTH_W = 20
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_wr_i,
  input logic [REG_W-1:0]   cfg_wdata_i,
  input logic [REG_W-1:0]   cfg_rdata_o,
  input logic               expire_i,
  input logic               tick_i,
  input logic               rst_pulse_o,
  input logic               rst_pulse_oe_o,
  input logic [WIDTH_W-1:0] cfg_width,
  input logic               key_hit,
  input logic               pulse_active,
  input logic [WIDTH_W-1:0] pulse_cnt,
  input logic               pulse_done
);

  logic [7:0] top_b;
  assign top_b = cfg_wdata_i[REG_W-1 -: 8];

  assert_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> cfg_rdata_o[WIDTH_W-1:0] == $past(cfg_wdata_i[WIDTH_W-1:0]));
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[REG_W-3:WIDTH_W] == '0);
  assert_pol_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && top_b == 8'hA5 |=> cfg_rdata_o[REG_W-1]);
  assert_pol_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && top_b == 8'h5A |=> !cfg_rdata_o[REG_W-1]);
  assert_drv_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && top_b == 8'hA8 |=> cfg_rdata_o[REG_W-2]);
  assert_drv_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && top_b == 8'h8A |=> !cfg_rdata_o[REG_W-2]);
  assert_keep_attr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_wr_i && key_hit) |=> $stable(cfg_rdata_o[REG_W-1 -: 2]));
  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> pulse_active && pulse_cnt == $past(cfg_width));
  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_done |=> !pulse_active);
  assert_idle_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_active |-> rst_pulse_o == !cfg_rdata_o[REG_W-1]);
  assert_pp_oe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[REG_W-2] |-> rst_pulse_oe_o);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_active && !expire_i && !tick_i |=> pulse_active && $stable(pulse_cnt));

endmodule

bind wdt_rstcfg wdt_rstcfg_chk #(.REG_W(REG_W), .WIDTH_W(WIDTH_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_wr_i       (cfg_wr_i),
  .cfg_wdata_i    (cfg_wdata_i),
  .cfg_rdata_o    (cfg_rdata_o),
  .expire_i       (expire_i),
  .tick_i         (tick_i),
  .rst_pulse_o    (rst_pulse_o),
  .rst_pulse_oe_o (rst_pulse_oe_o),
  .cfg_width      (cfg_width),
  .key_hit        (key_hit),
  .pulse_active   (pulse_active),
  .pulse_cnt      (pulse_cnt),
  .pulse_done     (pulse_done)
);

// File: tb/wdt_rstcfg_tb.sv
`timescale 1ns/1ps
module wdt_rstcfg_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        strobe = 1'b0;
  logic        tick = 1'b0;
  logic        rout, roe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [19:0] m_width;
  logic        m_pol, m_pp, m_active;
  logic [19:0] m_cnt;

  always #2.5 clk = ~clk;

  wdt_rstcfg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .expire_i(strobe), .tick_i(tick),
    .rst_pulse_o(rout), .rst_pulse_oe_o(roe)
  );

  function automatic logic [31:0] exp_read();
    return {m_pol, m_pp, 10'd0, m_width};
  endfunction
  function automatic logic exp_level();
    return ~(m_active ^ m_pol);
  endfunction
  function automatic logic exp_oe();
    return m_pp || (m_active && !m_pol);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(rdata === exp_read(), req, "read", rdata, exp_read());
    check(rout === exp_level(), "R8", "level", {31'd0, rout}, {31'd0, exp_level()});
    check(roe === exp_oe(), "R9", "enable", {31'd0, roe}, {31'd0, exp_oe()});
  endtask

  // Drive one cycle at the falling edge, advance the model, compare at the next falling edge.
  task automatic cyc(input logic w, input logic [31:0] d, input logic s,
                     input logic t, input string req);
    logic [19:0] old_w;
    wr = w; wdata = d; strobe = s; tick = t;
    old_w = m_width;
    if (w) begin
      m_width = d[19:0];
      case (d[31:24])
        8'hA5: m_pol = 1'b1;
        8'h5A: m_pol = 1'b0;
        8'hA8: m_pp  = 1'b1;
        8'h8A: m_pp  = 1'b0;
        default: ;
      endcase
    end
    if (s) begin
      m_active = 1'b1; m_cnt = old_w;
    end else if (m_active && t) begin
      if (m_cnt == 0) m_active = 1'b0;
      else m_cnt = m_cnt - 1;
    end
    @(posedge clk); @(negedge clk);
    wr = 1'b0; strobe = 1'b0; tick = 1'b0;
    check_all(req);
  endtask

  // Counts observed asserted cycles from a strobe until release, tick every cycle.
  task automatic run_out(output int n, input logic pol, input string req);
    n = 0;
    while ((rout === pol) && n < 64) begin
      n++;
      cyc(1'b0, 32'd0, 1'b0, 1'b1, req);
    end
  endtask

  initial begin
    @(posedge clk);
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL R6 watchdog actual=%0d expected<%0d", cycles, 100000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    logic [31:0] d;
    logic [7:0] keys [4];
    keys[0] = 8'hA5; keys[1] = 8'h5A; keys[2] = 8'hA8; keys[3] = 8'h8A;
    void'($urandom(32'h5EED_1234));
    m_width = 20'hFF; m_pol = 1'b0; m_pp = 1'b0; m_active = 1'b0; m_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdata === 32'h0000_00FF, "R1", "reset read", rdata, 32'hFF);
    check(rout === 1'b1 && roe === 1'b0, "R1", "reset pins", {30'd0, rout, roe}, 32'h2);

    cyc(1'b1, 32'hA500_0005, 1'b0, 1'b0, "R3");
    check(rdata === 32'h8000_0005, "R3", "set high", rdata, 32'h8000_0005);
    cyc(1'b1, 32'h5A00_0005, 1'b0, 1'b0, "R3");
    check(rdata[31] === 1'b0, "R3", "clear high", rdata, 32'h0000_0005);
    cyc(1'b1, 32'hA800_0007, 1'b0, 1'b0, "R4");
    check(rdata === 32'h4000_0007 && roe === 1'b1, "R4", "push-pull", rdata, 32'h4000_0007);
    cyc(1'b1, 32'h8A00_0007, 1'b0, 1'b0, "R4");
    check(rdata === 32'h0000_0007 && roe === 1'b0, "R4", "open-drain", rdata, 32'h7);
    cyc(1'b1, 32'hA500_0001, 1'b0, 1'b0, "R5");
    cyc(1'b1, 32'h0000_0009, 1'b0, 1'b0, "R5");
    check(rdata === 32'h8000_0009, "R5", "zero top byte", rdata, 32'h8000_0009);
    cyc(1'b1, 32'hA400_000A, 1'b0, 1'b0, "R5");
    check(rdata === 32'h8000_000A, "R5", "near-key byte", rdata, 32'h8000_000A);
    cyc(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R2");
    check(rdata === 32'h800F_FFFF, "R2", "reserved bits zero", rdata, 32'h800F_FFFF);

    cyc(1'b1, 32'h5A00_0003, 1'b0, 1'b0, "R6");
    cyc(1'b0, 32'd0, 1'b1, 1'b0, "R6");
    check(roe === 1'b1, "R9", "od asserted low enable", {31'd0, roe}, 32'd1);
    run_out(n, 1'b0, "R6");
    check(n == 4, "R6", "pulse length width 3", n, 4);
    check(roe === 1'b0, "R9", "od released", {31'd0, roe}, 32'd0);

    cyc(1'b1, 32'hA500_0005, 1'b0, 1'b0, "R7");
    cyc(1'b0, 32'd0, 1'b1, 1'b0, "R7");
    repeat (3) cyc(1'b0, 32'd0, 1'b0, 1'b1, "R7");
    cyc(1'b0, 32'd0, 1'b1, 1'b0, "R7");
    run_out(n, 1'b1, "R7");
    check(n == 6, "R7", "retrigger length", n, 6);

    cyc(1'b0, 32'd0, 1'b1, 1'b0, "R10");
    repeat (10) cyc(1'b0, 32'd0, 1'b0, 1'b0, "R10");
    check(rout === 1'b1, "R10", "held without ticks", {31'd0, rout}, 32'd1);
    run_out(n, 1'b1, "R10");
    check(n == 6, "R10", "resumes count", n, 6);

    cyc(1'b1, 32'h0000_0002, 1'b0, 1'b0, "R11");
    cyc(1'b1, 32'h0000_0009, 1'b1, 1'b0, "R11");
    cyc(1'b1, 32'h0000_0010, 1'b0, 1'b0, "R11");
    run_out(n, 1'b1, "R11");
    check(n == 3, "R11", "length captured at strobe", n, 3);

    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      d = $urandom();
      if (sel < 4) d[31:24] = keys[sel];
      if ($urandom_range(0, 7) != 0) d[19:0] = d[19:0] & 20'h7;
      cyc($urandom_range(0, 3) == 0, d, $urandom_range(0, 19) == 0,
          $urandom_range(0, 3) != 0, "R5");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule